// File: doc/BRIEF.md
# Aliased General Register File

This block holds eight 32-bit general registers for a processor core. Four of them are data registers. Each data register can be addressed as the whole word, as its low 16-bit half, or as either byte of that half. The other four registers are the stack pointer, the frame base pointer, the source index and the destination index. These can be addressed only as the whole word or as the low half. A write changes only the slice it names, and every other bit of the register keeps its value. Two read ports return the selected slice zero-extended to 32 bits. Reads are combinational on the current contents, so a write becomes visible on the cycle after its clock edge.

A separate stack-adjust port moves the stack pointer for push and pop without a general write. A push lowers the pointer by the operand size before the stack address is used. A pop presents the current pointer as the address and raises the pointer after the edge. When the stack width is 16 bits, the adjustment changes only the low half and wraps within it. All control pins are plain level signals sampled at the clock edge. There is no stream interface and no back-pressure: every request presented is accepted in its cycle.

Top module: `aliased_regfile`

## Requirements
- R1: A synchronous active-high `rst` clears all eight registers to zero at the next rising edge.
- R2: Register indices are 0 to 3 for the data registers, 4 for the stack pointer, 5 for the base pointer, 6 for the source index and 7 for the destination index. The size code is 2'b11 for 32 bits, 2'b10 for bits 15:0, 2'b01 for bits 15:8 and 2'b00 for bits 7:0. A 32-bit write replaces the whole register.
- R3: A 16-bit write (size 2'b10) loads `wr_data[15:0]` into bits 15:0 and keeps bits 31:16.
- R4: On a data register, a high-byte write loads `wr_data[7:0]` into bits 15:8, and a low-byte write loads it into bits 7:0. All other bits, including 31:16, are kept.
- R5: A byte-size write (size 2'b00 or 2'b01) to index 4..7 raises `wr_err` combinationally in that cycle and changes no register.
- R6: Each read port returns, combinationally, the selected slice of the current register contents, zero-extended to 32 bits. A byte slice appears in bits 7:0.
- R7: A byte-size read of index 4..7 raises that port's error flag and returns zero.
- R8: A push (`stk_en`=1, `stk_pop`=0) places SP minus 4 (`stk_wide`=1) or minus 2 (`stk_wide`=0) on `stk_addr` in the same cycle, and SP holds that value after the edge.
- R9: A pop (`stk_en`=1, `stk_pop`=1) places the current SP on `stk_addr`, and SP is raised by 4 or 2 after the edge.
- R10: With `stk_addr32`=0, the stack adjustment changes only SP bits 15:0, wraps modulo 2^16, and keeps bits 31:16. `stk_addr` bits 31:16 equal the current SP bits 31:16.
- R11: If a valid general write targets SP in the same cycle as a stack operation, the general write takes effect and the stack adjustment is dropped. An invalid (byte) general write to SP does not block the adjustment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | General write request |
| wr_idx | input | 3 | Register index for the write |
| wr_size | input | 2 | Size code for the write |
| wr_data | input | 32 | Write data, slice taken from the low bits |
| wr_err | output | 1 | Byte write to a non-data register (write suppressed) |
| stk_en | input | 1 | Stack adjust request |
| stk_pop | input | 1 | 1 = pop, 0 = push |
| stk_wide | input | 1 | Operand size: 1 = 4 bytes, 0 = 2 bytes |
| stk_addr32 | input | 1 | Stack width: 1 = 32-bit, 0 = 16-bit |
| stk_addr | output | 32 | Stack address used by the current operation |
| rd0_idx | input | 3 | Read port 0 register index |
| rd0_size | input | 2 | Read port 0 size code |
| rd0_data | output | 32 | Read port 0 zero-extended slice |
| rd0_err | output | 1 | Read port 0 invalid byte request |
| rd1_idx | input | 3 | Read port 1 register index |
| rd1_size | input | 2 | Read port 1 size code |
| rd1_data | output | 32 | Read port 1 zero-extended slice |
| rd1_err | output | 1 | Read port 1 invalid byte request |

## Verification
The bench builds the block with its default parameters: a 32-bit word, eight registers, four of them byte-addressable, and the stack pointer at index 4. With these values, every slice boundary is reachable: 15:8 against 7:0, and 31:16 against 15:0. The 16-bit stack wrap at zero is hit by the first push after reset. General-write and stack-adjust collisions on index 4 also occur in the randomized phase.

// File: rtl/aliased_rf_pkg.sv
package aliased_rf_pkg;
  typedef enum logic [1:0] {
    SZ_LO8 = 2'b00,
    SZ_HI8 = 2'b01,
    SZ_W16 = 2'b10,
    SZ_W32 = 2'b11
  } acc_size_e;

  function automatic logic size_is_byte(input logic [1:0] s);
    return !s[1];
  endfunction
endpackage

// File: rtl/rf_slice_merge.sv
module rf_slice_merge #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] old_word,
  input  logic [DATA_W-1:0] new_bits,
  input  logic [1:0]        size,
  output logic [DATA_W-1:0] merged
);
  import aliased_rf_pkg::*;
  localparam int HALF_W = 16;
  localparam int BYTE_W = 8;

  always_comb begin
    merged = old_word;
    unique case (acc_size_e'(size))
      SZ_W32: merged = new_bits;
      SZ_W16: merged[HALF_W-1:0] = new_bits[HALF_W-1:0];
      SZ_HI8: merged[HALF_W-1:BYTE_W] = new_bits[BYTE_W-1:0];
      SZ_LO8: merged[BYTE_W-1:0] = new_bits[BYTE_W-1:0];
      default: merged = old_word;
    endcase
  end
endmodule

// File: rtl/rf_slice_read.sv
module rf_slice_read #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] word,
  input  logic [1:0]        size,
  input  logic              byte_ok,
  output logic [DATA_W-1:0] data,
  output logic              err
);
  import aliased_rf_pkg::*;
  localparam int HALF_W = 16;
  localparam int BYTE_W = 8;

  always_comb begin
    data = '0;
    err  = size_is_byte(size) && !byte_ok;
    if (!err) begin
      unique case (acc_size_e'(size))
        SZ_W32: data = word;
        SZ_W16: data[HALF_W-1:0] = word[HALF_W-1:0];
        SZ_HI8: data[BYTE_W-1:0] = word[HALF_W-1:BYTE_W];
        SZ_LO8: data[BYTE_W-1:0] = word[BYTE_W-1:0];
        default: data = '0;
      endcase
    end
  end
endmodule

// File: rtl/rf_stack_adjust.sv
module rf_stack_adjust #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] sp,
  input  logic              pop,
  input  logic              wide,
  input  logic              addr32,
  output logic [DATA_W-1:0] sp_next,
  output logic [DATA_W-1:0] addr
);
  localparam int HALF_W = 16;

  logic [DATA_W-1:0] step;
  logic [DATA_W-1:0] full_next;
  logic [HALF_W-1:0] half_next;

  always_comb begin
    step      = wide ? DATA_W'(4) : DATA_W'(2);
    full_next = pop ? sp + step : sp - step;
    half_next = pop ? sp[HALF_W-1:0] + step[HALF_W-1:0]
                    : sp[HALF_W-1:0] - step[HALF_W-1:0];
    sp_next   = addr32 ? full_next : {sp[DATA_W-1:HALF_W], half_next};
    addr      = pop ? sp : sp_next;
  end
endmodule

// File: rtl/aliased_regfile.sv
module aliased_regfile #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  parameter int NUM_DATA = 4,
  parameter int SP_IDX   = 4,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [1:0]        wr_size,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_err,
  input  logic              stk_en,
  input  logic              stk_pop,
  input  logic              stk_wide,
  input  logic              stk_addr32,
  output logic [DATA_W-1:0] stk_addr,
  input  logic [IDX_W-1:0]  rd0_idx,
  input  logic [1:0]        rd0_size,
  output logic [DATA_W-1:0] rd0_data,
  output logic              rd0_err,
  input  logic [IDX_W-1:0]  rd1_idx,
  input  logic [1:0]        rd1_size,
  output logic [DATA_W-1:0] rd1_data,
  output logic              rd1_err
);
  import aliased_rf_pkg::*;
  localparam int NUM_RD = 2;
  localparam logic [IDX_W-1:0] FIRST_PTR = IDX_W'(NUM_DATA);
  localparam logic [IDX_W-1:0] SP_SEL    = IDX_W'(SP_IDX);

  logic [DATA_W-1:0] regs [NUM_REGS];
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] sp_next;
  logic              wr_ok;
  logic              stk_ok;

  assign wr_err = wr_en && (wr_idx >= FIRST_PTR) && size_is_byte(wr_size);
  assign wr_ok  = wr_en && !wr_err;
  assign stk_ok = stk_en && !(wr_ok && wr_idx == SP_SEL);

  rf_slice_merge #(.DATA_W(DATA_W)) u_merge (
    .old_word (regs[wr_idx]),
    .new_bits (wr_data),
    .size     (wr_size),
    .merged   (merged)
  );

  rf_stack_adjust #(.DATA_W(DATA_W)) u_stack (
    .sp      (regs[SP_IDX]),
    .pop     (stk_pop),
    .wide    (stk_wide),
    .addr32  (stk_addr32),
    .sp_next (sp_next),
    .addr    (stk_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else begin
      if (wr_ok) regs[wr_idx] <= merged;
      if (stk_ok) regs[SP_IDX] <= sp_next;
    end
  end

  // read ports
  logic [IDX_W-1:0]  rd_idx_a  [NUM_RD];
  logic [1:0]        rd_size_a [NUM_RD];
  logic [DATA_W-1:0] rd_data_a [NUM_RD];
  logic              rd_err_a  [NUM_RD];

  assign rd_idx_a[0]  = rd0_idx;
  assign rd_idx_a[1]  = rd1_idx;
  assign rd_size_a[0] = rd0_size;
  assign rd_size_a[1] = rd1_size;
  assign rd0_data     = rd_data_a[0];
  assign rd1_data     = rd_data_a[1];
  assign rd0_err      = rd_err_a[0];
  assign rd1_err      = rd_err_a[1];

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    rf_slice_read #(.DATA_W(DATA_W)) u_read (
      .word    (regs[rd_idx_a[p]]),
      .size    (rd_size_a[p]),
      .byte_ok (rd_idx_a[p] < FIRST_PTR),
      .data    (rd_data_a[p]),
      .err     (rd_err_a[p])
    );
  end

  // per-register checks
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_chk
    assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> (regs[i] == '0));

    if (i < NUM_DATA) begin : g_data
      assert_byte_keeps_upper_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == IDX_W'(i) && size_is_byte(wr_size))
        |=> (regs[i][DATA_W-1:16] == $past(regs[i][DATA_W-1:16])));
    end else begin : g_ptr
      assert_bad_write_ignored_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == IDX_W'(i) && size_is_byte(wr_size) && !(i == SP_IDX && stk_en))
        |=> $stable(regs[i]));
    end
  end

  assert_w16_keeps_upper_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_size == 2'b10 && wr_idx == IDX_W'(0))
    |=> (regs[0][DATA_W-1:16] == $past(regs[0][DATA_W-1:16])));

  assert_push_wide_R8: assert property (@(posedge clk) disable iff (rst)
    (stk_en && !stk_pop && stk_addr32 && !(wr_en && wr_idx == SP_SEL))
    |=> (regs[SP_IDX] == $past(regs[SP_IDX]) - ($past(stk_wide) ? DATA_W'(4) : DATA_W'(2))));

  assert_stack16_upper_R10: assert property (@(posedge clk) disable iff (rst)
    (stk_en && !stk_addr32 && !(wr_en && wr_idx == SP_SEL))
    |=> (regs[SP_IDX][DATA_W-1:16] == $past(regs[SP_IDX][DATA_W-1:16])));

  assert_general_wins_R11: assert property (@(posedge clk) disable iff (rst)
    (stk_en && wr_en && wr_idx == SP_SEL && wr_size == 2'b11)
    |=> (regs[SP_IDX] == $past(wr_data)));
endmodule

// File: tb/aliased_regfile_tb.sv
module aliased_regfile_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, stk_en, stk_pop, stk_wide, stk_addr32;
  logic [2:0]  wr_idx, rd0_idx, rd1_idx;
  logic [1:0]  wr_size, rd0_size, rd1_size;
  logic [31:0] wr_data, stk_addr, rd0_data, rd1_data;
  logic        wr_err, rd0_err, rd1_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  aliased_regfile u_dut (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size), .wr_data(wr_data), .wr_err(wr_err),
    .stk_en(stk_en), .stk_pop(stk_pop), .stk_wide(stk_wide), .stk_addr32(stk_addr32),
    .stk_addr(stk_addr),
    .rd0_idx(rd0_idx), .rd0_size(rd0_size), .rd0_data(rd0_data), .rd0_err(rd0_err),
    .rd1_idx(rd1_idx), .rd1_size(rd1_size), .rd1_data(rd1_data), .rd1_err(rd1_err)
  );

  bit [31:0] m [8];
  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic bit [31:0] m_read(int idx, bit [1:0] sz, output bit err);
    err = (sz[1] == 0) && idx >= 4;
    if (err) return 0;
    case (sz)
      2'b11: return m[idx];
      2'b10: return m[idx] & 32'h0000_FFFF;
      2'b01: return (m[idx] >> 8) & 32'hFF;
      default: return m[idx] & 32'hFF;
    endcase
  endfunction

  function automatic bit [31:0] m_sp_next(bit pop, bit wide, bit a32);
    int unsigned n = wide ? 4 : 2;
    bit [31:0] s = m[4];
    bit [15:0] lo;
    if (a32) return pop ? s + n : s - n;
    lo = pop ? s[15:0] + 16'(n) : s[15:0] - 16'(n);
    return {s[31:16], lo};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1; wr_en = 0; stk_en = 0;
    @(posedge clk);
    @(negedge clk);
    rst = 0;
    for (int i = 0; i < 8; i++) m[i] = 0;
  endtask

  task automatic step(string tag, bit we, bit [2:0] wi, bit [1:0] ws, bit [31:0] wd,
                      bit se, bit sp, bit sw, bit sa,
                      bit [2:0] r0i, bit [1:0] r0s, bit [2:0] r1i, bit [1:0] r1s);
    bit e0, e1, bad;
    bit [31:0] x0, x1, spn, cur;
    @(negedge clk);
    wr_en = we; wr_idx = wi; wr_size = ws; wr_data = wd;
    stk_en = se; stk_pop = sp; stk_wide = sw; stk_addr32 = sa;
    rd0_idx = r0i; rd0_size = r0s; rd1_idx = r1i; rd1_size = r1s;
    #1;
    x0 = m_read(r0i, r0s, e0);
    x1 = m_read(r1i, r1s, e1);
    chk(e0 ? "R7" : tag, "rd0_data", rd0_data, x0);
    chk(e1 ? "R7" : tag, "rd1_data", rd1_data, x1);
    chk("R7", "rd0_err", 32'(rd0_err), 32'(e0));
    chk("R7", "rd1_err", 32'(rd1_err), 32'(e1));
    bad = we && wi >= 4 && ws[1] == 0;
    if (we) chk("R5", "wr_err", 32'(wr_err), 32'(bad));
    spn = m_sp_next(sp, sw, sa);
    if (se) chk(!sa ? "R10" : (sp ? "R9" : "R8"), "stk_addr", stk_addr, sp ? m[4] : spn);
    @(posedge clk);
    if (we && !bad) begin
      cur = m[wi];
      case (ws)
        2'b11: cur = wd;
        2'b10: cur[15:0] = wd[15:0];
        2'b01: cur[15:8] = wd[7:0];
        default: cur[7:0] = wd[7:0];
      endcase
      m[wi] = cur;
    end
    if (se && !(we && !bad && wi == 4)) m[4] = spn;
  endtask

  task automatic peek(string tag, bit [2:0] idx, bit [1:0] sz);
    step(tag, 0, 0, 2'b11, 0, 0, 0, 0, 1, idx, sz, idx, 2'b11);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
    end
  end

  initial begin
    rst = 1; wr_en = 0; wr_idx = 0; wr_size = 0; wr_data = 0;
    stk_en = 0; stk_pop = 0; stk_wide = 0; stk_addr32 = 1;
    rd0_idx = 0; rd0_size = 3; rd1_idx = 0; rd1_size = 3;
    for (int i = 0; i < 8; i++) m[i] = 32'hDEAD_BEEF;
    do_reset();
    // R1: everything reads zero after reset
    for (int i = 0; i < 8; i++) peek("R1", 3'(i), 2'b11);
    // R2: full write
    step("R2", 1, 0, 2'b11, 32'h1122_3344, 0, 0, 0, 1, 0, 3, 1, 3);
    peek("R2", 0, 2'b11);
    chk("R2", "reg0 direct", rd0_data, 32'h1122_3344);
    // R4: byte writes keep the rest
    step("R4", 1, 0, 2'b01, 32'h0000_00AB, 0, 0, 0, 1, 0, 3, 1, 3);
    peek("R4", 0, 2'b11);
    chk("R4", "reg0 after hi8", rd0_data, 32'h1122_AB44);
    step("R4", 1, 0, 2'b00, 32'hFFFF_FFCD, 0, 0, 0, 1, 0, 3, 1, 3);
    peek("R4", 0, 2'b11);
    chk("R4", "reg0 after lo8", rd0_data, 32'h1122_ABCD);
    // R3: 16-bit write on index register
    step("R3", 1, 6, 2'b11, 32'hCAFE_0000, 0, 0, 0, 1, 0, 3, 1, 3);
    step("R3", 1, 6, 2'b10, 32'h1234_BEEF, 0, 0, 0, 1, 0, 3, 1, 3);
    peek("R3", 6, 2'b11);
    chk("R3", "reg6 after w16", rd0_data, 32'hCAFE_BEEF);
    // R5: byte write to base pointer rejected
    step("R5", 1, 5, 2'b00, 32'h55, 0, 0, 0, 1, 0, 3, 1, 3);
    peek("R5", 5, 2'b11);
    chk("R5", "reg5 unchanged", rd0_data, 32'h0);
    // R6: slice reads zero-extended
    peek("R6", 0, 2'b01);
    chk("R6", "hi8 read", rd0_data, 32'hAB);
    peek("R6", 0, 2'b10);
    chk("R6", "w16 read", rd0_data, 32'hABCD);
    // R7: byte read of pointer
    peek("R7", 4, 2'b01);
    chk("R7", "rd0_err on SP byte", 32'(rd0_err), 32'h1);
    // R10: 16-bit push from zero wraps in low half
    step("R10", 0, 0, 3, 0, 1, 0, 1, 0, 4, 3, 4, 3);
    peek("R10", 4, 2'b11);
    chk("R10", "SP after 16-bit push", rd0_data, 32'h0000_FFFC);
    // R8: 32-bit push by 2
    step("R8", 1, 4, 2'b11, 32'h0001_0000, 0, 0, 0, 1, 4, 3, 4, 3);
    step("R8", 0, 0, 3, 0, 1, 0, 0, 1, 4, 3, 4, 3);
    peek("R8", 4, 2'b11);
    chk("R8", "SP after push", rd0_data, 32'h0000_FFFE);
    // R9: pop by 4
    step("R9", 0, 0, 3, 0, 1, 1, 1, 1, 4, 3, 4, 3);
    peek("R9", 4, 2'b11);
    chk("R9", "SP after pop", rd0_data, 32'h0001_0002);
    // R11: collision, general write wins; invalid write does not block
    step("R11", 1, 4, 2'b11, 32'h0000_8000, 1, 0, 1, 1, 4, 3, 4, 3);
    peek("R11", 4, 2'b11);
    chk("R11", "SP general wins", rd0_data, 32'h0000_8000);
    step("R11", 1, 4, 2'b00, 32'h0000_0011, 1, 0, 1, 1, 4, 3, 4, 3);
    peek("R11", 4, 2'b11);
    chk("R11", "SP push despite bad write", rd0_data, 32'h0000_7FFC);
    // randomized phase compared against the model every cycle
    for (int k = 0; k < 4000; k++) begin
      if (k == 2000) begin
        do_reset();
        for (int i = 0; i < 8; i++) peek("R1", 3'(i), 2'b11);
      end
      step("R6", 1'($urandom), 3'($urandom), 2'($urandom), $urandom,
           1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           3'($urandom), 2'($urandom), 3'($urandom), 2'($urandom));
    end
    done = 1;
    finish_up();
  end
endmodule